// File: doc/BRIEF.md
# Burst Address Counter Unit

This unit produces the address that one port of a synchronous memory uses on each clock cycle. At every rising edge it samples four things: an external address bus, an active-low strobe that captures that bus, an active-low step input that moves the held address forward by one, and an active-low clear that forces the address to zero. The registered result drives the memory array directly. A burst therefore needs only one address transfer, followed by any number of step cycles. Hold cycles can be placed between the steps.

Every command takes effect on the edge where it is sampled. The address it selects is the one used by the access in that same cycle, so no idle cycle is inserted after a load, a step or a clear. Chip selects and byte masks do not gate the unit: it has no such inputs, and it advances whenever it is told to. The address width is a parameter. When the counter steps past its highest value it wraps to zero.

Top module: `burst_addr_unit`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, and after it is released but before any command is sampled, `access_addr` is 0.
- R2: When `clr_n` is 0 at a rising edge, `access_addr` becomes 0 right after that edge, whatever the values of `strobe_n`, `step_n` and `ext_addr`.
- R3: When `clr_n` is 1 and `strobe_n` is 0 at a rising edge, `access_addr` takes the `ext_addr` value sampled at that edge.
- R4: When `strobe_n` and `step_n` are both 0 and `clr_n` is 1, the load wins: `access_addr` equals the sampled `ext_addr`, not that value plus one.
- R5: When `clr_n` is 1, `strobe_n` is 1 and `step_n` is 0 at a rising edge, `access_addr` becomes its previous value plus one.
- R6: When `clr_n`, `strobe_n` and `step_n` are all 1 at a rising edge, `access_addr` keeps its value, and `ext_addr` has no effect on it.
- R7: A step from the all-ones address (16383 for the default 14-bit width) gives 0.
- R8: Commands given on consecutive edges each take effect at their own edge. For example, clear, step, step, load, step yields 0, 1, 2, A, A+1 on five consecutive cycles, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; sets the address to 0 |
| ext_addr | input | ADDR_W (14) | External address, captured when the strobe is active |
| strobe_n | input | 1 | Active-low strobe that loads `ext_addr` |
| step_n | input | 1 | Active-low counter enable; advances the address by one |
| clr_n | input | 1 | Active-low counter clear; has the highest priority |
| access_addr | output | ADDR_W (14) | Address used for the access in the current cycle |

## Verification
The assertions assume that `clr_n`, `strobe_n`, `step_n` and `ext_addr` hold known values at every sampled rising edge. They also assume reset is asserted asynchronously and released away from an edge. The bench meets this by changing every input only on the falling clock edge and by releasing reset there as well. It mixes directed sequences (priority collisions, wrap from the top address, back-to-back commands) with a long pseudo-random command stream. This stream is weighted toward steps and holds so that long bursts occur.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Command selected for one clock edge, ordered by nothing in particular;
    // the priority lives in the decoder.
    typedef enum logic [1:0] {
        CMD_KEEP  = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_ZERO  = 2'd3
    } addr_cmd_e;

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
    import burst_addr_pkg::*;
(
    input  logic      clr_n,
    input  logic      strobe_n,
    input  logic      step_n,
    output addr_cmd_e cmd
);

    // Priority: clear over load over step over keep.
    always_comb begin
        if (!clr_n) begin
            cmd = CMD_ZERO;
        end else if (!strobe_n) begin
            cmd = CMD_LOAD;
        end else if (!step_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_KEEP;
        end
    end

endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  addr_cmd_e          cmd,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [ADDR_W-1:0]  ext_addr,
    output logic [ADDR_W-1:0]  nxt_addr
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] inc_addr;

    // Modulo increment: the carry out of the top bit is dropped.
    always_comb begin
        inc_addr = cur_addr + ONE;
    end

    always_comb begin
        case (cmd)
            CMD_ZERO: nxt_addr = '0;
            CMD_LOAD: nxt_addr = ext_addr;
            CMD_STEP: nxt_addr = inc_addr;
            default:  nxt_addr = cur_addr;
        endcase
    end

endmodule

// File: rtl/burst_addr_unit.sv
module burst_addr_unit
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              clr_n,
    output logic [ADDR_W-1:0] access_addr
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } unit_state_t;

    unit_state_t st_d;
    unit_state_t st_q;

    addr_cmd_e         cmd_w;
    logic [ADDR_W-1:0] nxt_w;

    burst_addr_decode u_decode (
        .clr_n    (clr_n),
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .cmd      (cmd_w)
    );

    burst_addr_next #(
        .ADDR_W (ADDR_W)
    ) u_next (
        .cmd      (cmd_w),
        .cur_addr (st_q.addr),
        .ext_addr (ext_addr),
        .nxt_addr (nxt_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.addr = nxt_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign access_addr = st_q.addr;

    // Clear forces zero on the following cycle regardless of other inputs.
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (access_addr == '0));

    // Strobe loads the sampled bus; also covers strobe winning over step.
    p_strobe_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !strobe_n) |=> (access_addr == $past(ext_addr)));

    p_strobe_beats_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !strobe_n && !step_n) |=> (access_addr == $past(ext_addr)));

    p_step_plus_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && strobe_n && !step_n) |=>
            (access_addr == ADDR_W'($past(access_addr) + ADDR_W'(1))));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && strobe_n && step_n) |=> $stable(access_addr));

    p_top_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && strobe_n && !step_n && access_addr == TOP_ADDR) |=>
            (access_addr == '0));

endmodule

// File: tb/burst_addr_unit_test.sv
module burst_addr_unit_test;

    localparam int AW   = 14;
    localparam int SPAN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          step_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [AW-1:0] access_addr;

    int compared   = 0;
    int mismatched = 0;
    int model      = 0;
    bit finished   = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_unit #(.ADDR_W(AW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_addr    (ext_addr),
        .strobe_n    (strobe_n),
        .step_n      (step_n),
        .clr_n       (clr_n),
        .access_addr (access_addr)
    );

    task automatic check(input string req, input int got, input int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // One clock: drive on the falling edge, update the model, sample after the rising edge.
    task automatic cycle(input string req, input bit c, input bit s, input bit e, input int a);
        @(negedge clk);
        clr_n    = c;
        strobe_n = s;
        step_n   = e;
        ext_addr = AW'(a);
        if (!c)      model = 0;
        else if (!s) model = a % SPAN;
        else if (!e) model = (model + 1) % SPAN;
        @(posedge clk);
        #1;
        check(req, int'(access_addr), model);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and just after reset.
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(access_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", int'(access_addr), 0);

        // R3: plain loads.
        cycle("R3", 1, 0, 1, 1234);
        cycle("R3", 1, 0, 1, 77);
        // R6: hold with a changing bus.
        cycle("R6", 1, 1, 1, 9999);
        cycle("R6", 1, 1, 1, 5);
        // R5: steps.
        cycle("R5", 1, 1, 0, 0);
        cycle("R5", 1, 1, 0, 3000);
        // R4: strobe and step together.
        cycle("R4", 1, 0, 0, 500);
        // R2: clear overrides strobe and step.
        cycle("R2", 0, 0, 0, 4321);
        cycle("R3", 1, 0, 1, 42);
        cycle("R2", 0, 1, 1, 8);
        // R7: wrap from the top address.
        cycle("R3", 1, 0, 1, SPAN - 2);
        cycle("R5", 1, 1, 0, 0);
        cycle("R7", 1, 1, 0, 0);
        cycle("R7", 1, 1, 0, 0);
        // R8: back-to-back commands.
        cycle("R8", 0, 1, 1, 0);
        cycle("R8", 1, 1, 0, 0);
        cycle("R8", 1, 1, 0, 0);
        cycle("R8", 1, 0, 1, 700);
        cycle("R8", 1, 1, 0, 0);

        // Weighted random stream, each cycle tagged by the command given.
        for (int i = 0; i < 4000; i++) begin
            int  r = int'($urandom_range(0, 99));
            int  a = int'($urandom_range(0, SPAN - 1));
            bit  c = (r >= 3);
            bit  s = !(r >= 3 && r < 15) && !(r >= 95);
            bit  e = !((r >= 15 && r < 70) || r >= 95);
            string tag;
            if (i % 500 == 0) begin
                a = SPAN - 1;
                s = 1'b0;
                e = 1'b1;
                c = 1'b1;
            end
            if (!c)            tag = "R2";
            else if (!s && !e) tag = "R4";
            else if (!s)       tag = "R3";
            else if (!e)       tag = (model == SPAN - 1) ? "R7" : "R5";
            else               tag = "R6";
            cycle(tag, c, s, e, a);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule